// File: doc/BRIEF.md
# Masked Input Change Event Generator

This block watches a vector of input states and turns changes into a stream of per-channel events. On a sample strobe it compares the live input vector with a stored reference vector. Every enabled channel whose bit differs produces one event carrying the channel index and a direction flag: rising when the new value is 1, falling when it is 0. The events for one sample leave over a valid/ready stream, lowest channel first, at most one per cycle. Once a sample is taken, the whole sampled vector becomes the new reference. This includes channels whose events are disabled.

Software or a neighbouring block controls which channels report, one channel per write through a small mask port. When a channel is enabled, its reference bit is reloaded from the live input in the same cycle. A state the input held before the channel was enabled therefore never produces an event. Disabling a channel only clears its enable bit.

The control is a two-state machine. `ST_IDLE` waits for a strobe. On the *accept-with-changes* transition it captures the pending change set and moves to `ST_EMIT`. On *accept-quiet* there were no enabled changes, so the machine stays in `ST_IDLE`. `ST_EMIT` presents one event at a time. On the *last-handshake* transition it returns to `ST_IDLE`. A strobe is taken only in `ST_IDLE`, and `busy` is high in `ST_EMIT`.

Top module: `chg_evt_gen`

## Requirements
- R1: After reset, all channels are enabled, every reference bit is 0, and both `busy` and `evt_valid` are low.
- R2: A strobe accepted while `busy` is low produces exactly the events of the set bits of (reference XOR `live_in`) AND enable mask. If that set is empty, no event appears and `busy` stays low.
- R3: `evt_rise` is 1 when the channel's sampled value is 1, and 0 when it is 0.
- R4: Events of one sample leave in strictly ascending `evt_chan` order. The first is valid in the cycle after the strobe edge, and with `evt_ready` held high one event completes per cycle.
- R5: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_chan` and `evt_rise` hold their values.
- R6: A channel whose enable bit is 0 produces no event.
- R7: Writing `mask_wr`=1 with `mask_en`=1 loads reference bit `mask_idx` from `live_in[mask_idx]`. A later sample equal to that value yields no event on that channel, and a different value yields one.
- R8: Writing `mask_en`=0 clears only the enable bit. A later re-enable reseeds the reference again from the live input.
- R9: A strobe while `busy` is high is ignored. It adds no events and does not change the reference.
- R10: A mask write and a strobe in the same cycle take effect mask first. A channel disabled in that cycle gives no event, and a channel enabled in that cycle gives no event.
- R11: After a sample is accepted, the reference equals that sample, so the same vector strobed again yields no events.
- R12: Mask writes while `busy` is high do not alter the events still pending from the sample being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_in | input | NCH | Current input states, sampled on a strobe and used for reseeding |
| sample_stb | input | 1 | Take `live_in` as a new sample (honoured only when not busy) |
| mask_wr | input | 1 | Write one channel's enable bit |
| mask_idx | input | CW | Channel addressed by the mask write |
| mask_en | input | 1 | 1 enables (and reseeds), 0 disables |
| busy | output | 1 | Events of the last sample are still draining |
| evt_valid | output | 1 | Event on the output stream is valid |
| evt_ready | input | 1 | Consumer accepts the event this cycle |
| evt_chan | output | CW | Channel index of the event |
| evt_rise | output | 1 | Direction: 1 rising, 0 falling |

## Verification
A corrupted reference bit shows at the ports as a missing or spurious event on the next accepted strobe that involves that channel. This holds even when it is the same vector strobed twice. A wrong pending set or a faulty lowest-bit pick shows within one cycle of the strobe as a wrong index, a wrong count or a broken ascending order. A machine that leaves `ST_EMIT` early or late shows as `busy` disagreeing with the number of events seen, or as an ignored strobe that sneaks extra events in. With back-pressure applied, a pending set that changes outside a handshake appears at once as an unstable index.

// File: rtl/chg_evt_pkg.sv
package chg_evt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } evt_state_e;

endpackage

// File: rtl/chg_ref_store.sv
// Per-channel enable bit and reference bit, with same-cycle mask-first
// ordering between a mask write and an accepted sample.
module chg_ref_store #(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] live_in,
    input  logic           mask_wr,
    input  logic [CW-1:0]  mask_idx,
    input  logic           mask_en,
    input  logic           take,
    output logic [NCH-1:0] eff_mask,
    output logic [NCH-1:0] seed_ref
);

    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] ref_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit;
        logic nxt_ref;

        always_comb begin
            hit         = mask_wr && (mask_idx == CW'(g));
            eff_mask[g] = hit ? mask_en : mask_q[g];
            seed_ref[g] = (hit && mask_en) ? live_in[g] : ref_q[g];
            nxt_ref     = take ? live_in[g] : seed_ref[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b1;
                ref_q[g]  <= 1'b0;
            end else begin
                mask_q[g] <= eff_mask[g];
                ref_q[g]  <= nxt_ref;
            end
        end
    end

endmodule

// File: rtl/chg_lsb_pick.sv
// Index of the lowest set bit of a vector (0 when empty).
module chg_lsb_pick #(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] vec,
    output logic [CW-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = CW'(i);
            end
        end
    end

endmodule

// File: rtl/chg_evt_fsm.sv
// Two-state serializer: captures the change set on accept and hands out
// one event per handshake, lowest channel first.
module chg_evt_fsm
    import chg_evt_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample_stb,
    input  logic [NCH-1:0] diff_in,
    input  logic [NCH-1:0] live_in,
    input  logic           evt_ready,
    output logic           take,
    output logic           busy,
    output logic           evt_valid,
    output logic [CW-1:0]  evt_chan,
    output logic           evt_rise
);

    evt_state_e     state_q, state_d;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] snap_q;
    logic [NCH-1:0] pend_rest;
    logic [CW-1:0]  pick_idx;
    logic           hs;

    chg_lsb_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .vec (pend_q),
        .idx (pick_idx)
    );

    // Clearing the lowest set bit: x & (x - 1).
    assign pend_rest = pend_q & (pend_q - NCH'(1));

    // Output decode.
    always_comb begin
        take      = 1'b0;
        busy      = 1'b0;
        evt_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: take = sample_stb;
            ST_EMIT: begin
                busy      = 1'b1;
                evt_valid = 1'b1;
            end
            default: ;
        endcase
        evt_chan = pick_idx;
        evt_rise = snap_q[pick_idx];
    end

    assign hs = evt_valid && evt_ready;

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && (diff_in != '0)) state_d = ST_EMIT;
            ST_EMIT: if (hs && (pend_rest == '0)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pending set and sample snapshot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            snap_q <= '0;
        end else if (take) begin
            pend_q <= diff_in;
            snap_q <= live_in;
        end else if (hs) begin
            pend_q <= pend_rest;
        end
    end

endmodule

// File: rtl/chg_evt_gen.sv
module chg_evt_gen #(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] live_in,
    input  logic           sample_stb,
    input  logic           mask_wr,
    input  logic [CW-1:0]  mask_idx,
    input  logic           mask_en,
    output logic           busy,
    output logic           evt_valid,
    input  logic           evt_ready,
    output logic [CW-1:0]  evt_chan,
    output logic           evt_rise
);

    logic [NCH-1:0] eff_mask;
    logic [NCH-1:0] seed_ref;
    logic [NCH-1:0] diff;
    logic           take;

    chg_ref_store #(.NCH(NCH), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_in  (live_in),
        .mask_wr  (mask_wr),
        .mask_idx (mask_idx),
        .mask_en  (mask_en),
        .take     (take),
        .eff_mask (eff_mask),
        .seed_ref (seed_ref)
    );

    assign diff = (seed_ref ^ live_in) & eff_mask;

    chg_evt_fsm #(.NCH(NCH), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .diff_in    (diff),
        .live_in    (live_in),
        .evt_ready  (evt_ready),
        .take       (take),
        .busy       (busy),
        .evt_valid  (evt_valid),
        .evt_chan   (evt_chan),
        .evt_rise   (evt_rise)
    );

endmodule

// File: rtl/chg_evt_gen_chk.sv
module chg_evt_gen_chk #(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] live_in,
    input logic           sample_stb,
    input logic           busy,
    input logic           evt_valid,
    input logic           evt_ready,
    input logic [CW-1:0]  evt_chan,
    input logic           evt_rise
);

    logic [NCH-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (sample_stb && !busy) begin
            seen_q <= live_in;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_chan) && $stable(evt_rise)));

    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> (!evt_valid || (evt_chan > $past(evt_chan))));

    // R2
    no_spont_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sample_stb) |=> !evt_valid);

    // R3
    dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_rise == seen_q[evt_chan]));

    // R9
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(evt_valid && evt_ready)) |=> busy);

endmodule

bind chg_evt_gen chg_evt_gen_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .live_in    (live_in),
    .sample_stb (sample_stb),
    .busy       (busy),
    .evt_valid  (evt_valid),
    .evt_ready  (evt_ready),
    .evt_chan   (evt_chan),
    .evt_rise   (evt_rise)
);

// File: tb/chg_evt_gen_tb.sv
`timescale 1ns/1ps
module chg_evt_gen_tb;

    localparam int NCH = 32;
    localparam int CW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] live_in = '0;
    logic           sample_stb = 1'b0;
    logic           mask_wr = 1'b0;
    logic [CW-1:0]  mask_idx = '0;
    logic           mask_en = 1'b0;
    logic           busy;
    logic           evt_valid;
    logic           evt_ready = 1'b1;
    logic [CW-1:0]  evt_chan;
    logic           evt_rise;

    int checks = 0;
    int errors = 0;

    // Bench-side model built from the requirements.
    logic [NCH-1:0] m_ref  = '0;
    logic [NCH-1:0] m_mask = '1;
    logic [NCH-1:0] e_diff = '0;
    logic [NCH-1:0] e_val  = '0;

    always #2 clk = ~clk;

    chg_evt_gen #(.NCH(NCH), .CW(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_in    (live_in),
        .sample_stb (sample_stb),
        .mask_wr    (mask_wr),
        .mask_idx   (mask_idx),
        .mask_en    (mask_en),
        .busy       (busy),
        .evt_valid  (evt_valid),
        .evt_ready  (evt_ready),
        .evt_chan   (evt_chan),
        .evt_rise   (evt_rise)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_mask(input int idx, input logic en, input logic [NCH-1:0] lv);
        if (en) m_ref[idx] = lv[idx];
        m_mask[idx] = en;
    endtask

    task automatic model_sample(input logic [NCH-1:0] v);
        e_diff = (m_ref ^ v) & m_mask;
        e_val  = v;
        m_ref  = v;
    endtask

    // Strobe one sample (inputs change at negedge).
    task automatic do_sample(input logic [NCH-1:0] v);
        model_sample(v);
        live_in    = v;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic do_mask(input int idx, input logic en);
        model_mask(idx, en, live_in);
        mask_wr  = 1'b1;
        mask_idx = CW'(idx);
        mask_en  = en;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    // Drain with ready high; expect events of e_diff, ascending, one per cycle.
    task automatic drain(input string req);
        evt_ready = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (e_diff[i]) begin
                check(req, "event valid", 32'(evt_valid), 32'd1);
                check(req, "event channel", 32'(evt_chan), 32'(i));
                check("R3", "event direction", 32'(evt_rise), 32'(e_val[i]));
                @(negedge clk);
            end
        end
        check(req, "valid low after drain", 32'(evt_valid), 32'd0);
        check(req, "busy low after drain", 32'(busy), 32'd0);
    endtask

    task automatic t_reset;
        check("R1", "valid after reset", 32'(evt_valid), 32'd0);
        check("R1", "busy after reset", 32'(busy), 32'd0);
        do_sample('0);
        drain("R1");
        do_sample('1);
        drain("R1");
    endtask

    task automatic t_patterns;
        do_sample(32'h0000_F0F0);
        drain("R4");
        do_sample(32'h8001_0F0F);
        drain("R2");
        do_sample(32'h8001_0F0F);
        check("R11", "no event on repeat", 32'(evt_valid), 32'd0);
        drain("R11");
    endtask

    task automatic t_masking;
        for (int i = 0; i < 8; i++) do_mask(i, 1'b0);
        do_sample(32'h7FFE_F0F0);
        drain("R6");
        live_in = 32'h0000_0008;
        do_mask(3, 1'b1);
        do_sample(32'h0000_0008);
        drain("R7");
        live_in = 32'h0000_0000;
        do_mask(5, 1'b1);
        do_sample(32'h0000_0020);
        drain("R7");
        do_mask(3, 1'b0);
        do_sample(32'h0000_0000);
        drain("R8");
        live_in = 32'h0000_0008;
        do_mask(3, 1'b1);
        do_sample(32'h0000_0008);
        drain("R8");
    endtask

    task automatic t_backpressure;
        logic [CW-1:0] held;
        evt_ready = 1'b0;
        do_sample(32'h0000_1C08);
        held = evt_chan;
        for (int k = 0; k < 3; k++) begin
            check("R5", "valid held", 32'(evt_valid), 32'd1);
            check("R5", "channel held", 32'(evt_chan), 32'(held));
            @(negedge clk);
        end
        drain("R5");
    endtask

    task automatic t_busy_strobe;
        logic [NCH-1:0] first;
        first = 32'h0000_0306;
        evt_ready = 1'b0;
        do_sample(first);
        live_in    = 32'hFFFF_0000;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check("R9", "busy while draining", 32'(busy), 32'd1);
        drain("R9");
        do_sample(first);
        check("R9", "reference kept first sample", 32'(evt_valid), 32'd0);
        drain("R9");
    endtask

    task automatic t_same_cycle;
        logic [NCH-1:0] v;
        v = m_ref ^ 32'h0000_0006;
        model_mask(1, 1'b0, v);
        model_sample(v);
        live_in = v; sample_stb = 1'b1;
        mask_wr = 1'b1; mask_idx = 5'd1; mask_en = 1'b0;
        @(negedge clk);
        sample_stb = 1'b0; mask_wr = 1'b0;
        drain("R10");
        do_mask(2, 1'b0);
        v = m_ref ^ 32'h0000_0004;
        model_mask(2, 1'b1, v);
        model_sample(v);
        live_in = v; sample_stb = 1'b1;
        mask_wr = 1'b1; mask_idx = 5'd2; mask_en = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; mask_wr = 1'b0;
        check("R10", "no event on channel enabled with strobe", 32'(evt_valid), 32'd0);
        drain("R10");
    endtask

    task automatic t_mask_while_busy;
        evt_ready = 1'b0;
        do_sample(m_ref ^ 32'h0000_0C00);
        do_mask(11, 1'b0);
        check("R12", "busy during mask write", 32'(busy), 32'd1);
        drain("R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_masking();
        t_backpressure();
        t_busy_strobe();
        t_same_cycle();
        t_mask_while_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual hung expected drained");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule